// File: doc/BRIEF.md
# Execute-Stage Operand Forwarding and Load-Use Stall Unit

This block resolves data hazards for the execute stage of a five-stage, 16-bit pipeline with eight architectural registers. The highest register index is not a storage register. Any read of it returns the program counter of the consuming instruction. For every source operand of the instruction in Execute, the unit compares the source register index with the destinations of the instructions in the Mem and Writeback stages. It then picks one of four operand values: the value read from the register file, the Mem-stage ALU result, the Writeback data, or the current PC.

A load cannot forward from Mem because its data is not ready yet. When the nearest producer of a source is a load sitting in Mem, the unit raises a stall instead. The stall freezes the PC and every pipeline register ahead of Execute, and it turns the Execute/Mem register into a bubble. On the next cycle the load has moved to Writeback and the frozen instruction in Execute is evaluated again. This time its operand arrives through ordinary Writeback forwarding.

The unit also holds the register-read bypass of the register file. When a read port addresses the register that the Writeback stage is writing in the same cycle, the port returns the data being written. The unit is fully combinational and sits between the pipeline registers it observes. The register storage itself lies outside the block.

Top module: `hz_exec_forward`

## Requirements
- R1: A source whose index is 7 (all ones) takes the PC value and reports selector 3. It never raises a stall, whatever the Mem and Writeback stages hold.
- R2: A source that is not 7 matches the Mem stage when three things hold: the Mem valid bit is 1, the Mem write enable is 1, and the Mem destination equals the source index. If the Mem instruction is not a load, the operand is the Mem ALU result and the selector is 1.
- R3: When a source matches both the Mem and Writeback stages, the Mem match wins.
- R4: A source that is not 7 and does not match Mem, but does match Writeback (Writeback valid 1, Writeback write enable 1, equal destination), takes the Writeback data and reports selector 2.
- R5: A source with no match takes its register-file value unchanged and reports selector 0.
- R6: A Mem match on a load raises that source's stall request. The stall output is the OR of the requests of all sources.
- R7: The PC hold, front-register hold and Execute/Mem bubble outputs are each equal to the stall output in every cycle.
- R8: A stage whose valid bit is 0, or whose write enable is 0, never produces a match or a stall. The search then falls through to the next stage, or to the register file.
- R9: A register-read port returns the Writeback data when Writeback valid and write enable are both 1 and the read index equals the Writeback destination. Otherwise it returns the raw register-file data.
- R10: After a load-use stall, the same sources with the load now in Writeback and a bubble in Mem select selector 2, receive the load data, and raise no stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pc_val | input | DW | PC of the instruction in Execute |
| ex_src_addr | input | NSRC x AW | Source register indices of the Execute instruction |
| ex_rf_val | input | NSRC x DW | Register values latched at register read |
| mem_valid | input | 1 | Mem stage holds a real instruction |
| mem_wr | input | 1 | Mem instruction writes a register |
| mem_load | input | 1 | Mem instruction is a load |
| mem_dst | input | AW | Mem destination register index |
| mem_alu | input | DW | Mem-stage ALU result |
| wb_valid | input | 1 | Writeback stage holds a real instruction |
| wb_wr | input | 1 | Writeback instruction writes a register |
| wb_dst | input | AW | Writeback destination register index |
| wb_data | input | DW | Writeback result data |
| rr_addr | input | NSRC x AW | Register-read stage read indices |
| rr_raw | input | NSRC x DW | Raw register-file read data |
| rr_data | output | NSRC x DW | Read data after write-to-read bypass |
| ex_opnd | output | NSRC x DW | Forwarded operands for Execute |
| ex_sel | output | NSRC x 2 | Operand source per port: 0 file, 1 Mem, 2 Writeback, 3 PC |
| stall | output | 1 | Load-use stall |
| hold_pc | output | 1 | Disable PC write |
| hold_front | output | 1 | Disable writes of the pipeline registers ahead of Execute |
| exmem_bubble | output | 1 | Load a bubble into the Execute/Mem register |

## Verification
Every result is combinational, so it is due in the same cycle as the stimulus that causes it, with no register in the path. The driver changes the inputs on the falling clock edge and queues the values the requirements predict. The monitor pops and compares them on the next rising edge, half a period later, when the inputs are settled. The two-cycle stall-then-recompute sequence is applied as two consecutive driven cycles, and each cycle's expectation is queued on its own.

// File: rtl/hz_fwd_pkg.sv
package hz_fwd_pkg;
  // Operand source code reported per port; the values are part of the interface.
  typedef enum logic [1:0] {
    OPND_RF  = 2'd0,
    OPND_MEM = 2'd1,
    OPND_WB  = 2'd2,
    OPND_PC  = 2'd3
  } opnd_src_e;
endpackage

// File: rtl/hz_rf_bypass.sv
module hz_rf_bypass #(
  parameter int AW = 3,
  parameter int DW = 16
) (
  input  logic [AW-1:0] rd_addr,
  input  logic [DW-1:0] rd_raw,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_data
);
  // The write lands at the end of the cycle; pass it straight to a same-index read.
  assign rd_data = (wr_en && (rd_addr == wr_addr)) ? wr_data : rd_raw;
endmodule

// File: rtl/hz_opnd_select.sv
module hz_opnd_select
  import hz_fwd_pkg::*;
#(
  parameter int AW = 3,
  parameter int DW = 16
) (
  input  logic [AW-1:0] src_addr,
  input  logic [DW-1:0] rf_val,
  input  logic [DW-1:0] pc_val,
  input  logic          mem_valid,
  input  logic          mem_wr,
  input  logic          mem_load,
  input  logic [AW-1:0] mem_dst,
  input  logic [DW-1:0] mem_alu,
  input  logic          wb_valid,
  input  logic          wb_wr,
  input  logic [AW-1:0] wb_dst,
  input  logic [DW-1:0] wb_data,
  output logic [DW-1:0] opnd,
  output opnd_src_e     sel,
  output logic          stall_req
);
  localparam logic [AW-1:0] PC_IDX = '1;

  logic is_pc, mem_hit, wb_hit;

  assign is_pc   = (src_addr == PC_IDX);
  assign mem_hit = mem_valid && mem_wr && (mem_dst == src_addr);
  assign wb_hit  = wb_valid && wb_wr && (wb_dst == src_addr);

  always_comb begin
    sel       = OPND_RF;
    opnd      = rf_val;
    stall_req = 1'b0;
    if (is_pc) begin
      sel  = OPND_PC;
      opnd = pc_val;
    end else if (mem_hit) begin
      // A load's value is not ready: the operand is discarded by the stall.
      sel       = OPND_MEM;
      opnd      = mem_alu;
      stall_req = mem_load;
    end else if (wb_hit) begin
      sel  = OPND_WB;
      opnd = wb_data;
    end
  end
endmodule

// File: rtl/hz_stall_ctrl.sv
module hz_stall_ctrl #(
  parameter int NSRC = 3
) (
  input  logic [NSRC-1:0] req,
  output logic            stall,
  output logic            hold_pc,
  output logic            hold_front,
  output logic            exmem_bubble
);
  assign stall        = |req;
  assign hold_pc      = stall;
  assign hold_front   = stall;
  assign exmem_bubble = stall;
endmodule

// File: rtl/hz_exec_forward.sv
module hz_exec_forward
  import hz_fwd_pkg::*;
#(
  parameter int AW   = 3,
  parameter int DW   = 16,
  parameter int NSRC = 3
) (
  input  logic [DW-1:0]            pc_val,
  input  logic [NSRC-1:0][AW-1:0]  ex_src_addr,
  input  logic [NSRC-1:0][DW-1:0]  ex_rf_val,
  input  logic                     mem_valid,
  input  logic                     mem_wr,
  input  logic                     mem_load,
  input  logic [AW-1:0]            mem_dst,
  input  logic [DW-1:0]            mem_alu,
  input  logic                     wb_valid,
  input  logic                     wb_wr,
  input  logic [AW-1:0]            wb_dst,
  input  logic [DW-1:0]            wb_data,
  input  logic [NSRC-1:0][AW-1:0]  rr_addr,
  input  logic [NSRC-1:0][DW-1:0]  rr_raw,
  output logic [NSRC-1:0][DW-1:0]  rr_data,
  output logic [NSRC-1:0][DW-1:0]  ex_opnd,
  output logic [NSRC-1:0][1:0]     ex_sel,
  output logic                     stall,
  output logic                     hold_pc,
  output logic                     hold_front,
  output logic                     exmem_bubble
);
  logic            rf_wr_en;
  logic [NSRC-1:0] req;
  opnd_src_e       sel_e [NSRC];

  assign rf_wr_en = wb_valid && wb_wr;

  for (genvar k = 0; k < NSRC; k++) begin : g_port
    hz_rf_bypass #(.AW(AW), .DW(DW)) u_byp (
      .rd_addr (rr_addr[k]),
      .rd_raw  (rr_raw[k]),
      .wr_en   (rf_wr_en),
      .wr_addr (wb_dst),
      .wr_data (wb_data),
      .rd_data (rr_data[k])
    );

    hz_opnd_select #(.AW(AW), .DW(DW)) u_sel (
      .src_addr  (ex_src_addr[k]),
      .rf_val    (ex_rf_val[k]),
      .pc_val    (pc_val),
      .mem_valid (mem_valid),
      .mem_wr    (mem_wr),
      .mem_load  (mem_load),
      .mem_dst   (mem_dst),
      .mem_alu   (mem_alu),
      .wb_valid  (wb_valid),
      .wb_wr     (wb_wr),
      .wb_dst    (wb_dst),
      .wb_data   (wb_data),
      .opnd      (ex_opnd[k]),
      .sel       (sel_e[k]),
      .stall_req (req[k])
    );

    assign ex_sel[k] = sel_e[k];
  end

  hz_stall_ctrl #(.NSRC(NSRC)) u_stall (
    .req          (req),
    .stall        (stall),
    .hold_pc      (hold_pc),
    .hold_front   (hold_front),
    .exmem_bubble (exmem_bubble)
  );
endmodule

// File: rtl/hz_exec_forward_chk.sv
module hz_exec_forward_chk #(
  parameter int AW   = 3,
  parameter int DW   = 16,
  parameter int NSRC = 3
) (
  input logic [DW-1:0]            pc_val,
  input logic [NSRC-1:0][AW-1:0]  ex_src_addr,
  input logic [NSRC-1:0][DW-1:0]  ex_rf_val,
  input logic                     mem_valid,
  input logic                     mem_wr,
  input logic                     mem_load,
  input logic [AW-1:0]            mem_dst,
  input logic [DW-1:0]            mem_alu,
  input logic                     wb_valid,
  input logic                     wb_wr,
  input logic [AW-1:0]            wb_dst,
  input logic [DW-1:0]            wb_data,
  input logic [NSRC-1:0][AW-1:0]  rr_addr,
  input logic [NSRC-1:0][DW-1:0]  rr_raw,
  input logic [NSRC-1:0][DW-1:0]  rr_data,
  input logic [NSRC-1:0][DW-1:0]  ex_opnd,
  input logic [NSRC-1:0][1:0]     ex_sel,
  input logic                     stall,
  input logic                     hold_pc,
  input logic                     hold_front,
  input logic                     exmem_bubble
);
  localparam logic [AW-1:0] PC_IDX = '1;

  logic known;
  assign known = !$isunknown({pc_val, ex_src_addr, ex_rf_val, mem_valid, mem_wr,
                              mem_load, mem_dst, mem_alu, wb_valid, wb_wr, wb_dst,
                              wb_data, rr_addr, rr_raw});

  always_comb begin
    if (known) begin
      AST_HOLD_TRACKS_STALL: assert (hold_pc == stall && hold_front == stall && exmem_bubble == stall); // R7
      AST_STALL_NEEDS_LOAD: assert (!stall || (mem_valid && mem_wr && mem_load)); // R8
      for (int k = 0; k < NSRC; k++) begin
        if (ex_src_addr[k] == PC_IDX) begin
          AST_PC_OPERAND: assert (ex_sel[k] == 2'd3 && ex_opnd[k] == pc_val); // R1
        end
        if (ex_src_addr[k] != PC_IDX && mem_valid && mem_wr && mem_dst == ex_src_addr[k]) begin
          if (mem_load) begin
            AST_LOAD_USE_STALL: assert (stall); // R6
          end else begin
            AST_MEM_PRIORITY: assert (ex_sel[k] == 2'd1 && ex_opnd[k] == mem_alu); // R3
          end
        end
        if (ex_sel[k] == 2'd2) begin
          AST_WB_OPERAND: assert (ex_opnd[k] == wb_data && wb_valid && wb_wr && wb_dst == ex_src_addr[k]); // R4
        end
        if (wb_valid && wb_wr && rr_addr[k] == wb_dst) begin
          AST_READ_BYPASS: assert (rr_data[k] == wb_data); // R9
        end else begin
          AST_READ_RAW: assert (rr_data[k] == rr_raw[k]); // R9
        end
      end
    end
  end
endmodule

bind hz_exec_forward hz_exec_forward_chk #(.AW(AW), .DW(DW), .NSRC(NSRC)) u_chk (.*);

// File: tb/hz_exec_forward_test.sv
module hz_exec_forward_test;
  localparam int AW = 3;
  localparam int DW = 16;
  localparam int NSRC = 3;

  logic clk = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  logic [DW-1:0]           pc_val;
  logic [NSRC-1:0][AW-1:0] ex_src_addr;
  logic [NSRC-1:0][DW-1:0] ex_rf_val;
  logic                    mem_valid, mem_wr, mem_load;
  logic [AW-1:0]           mem_dst;
  logic [DW-1:0]           mem_alu;
  logic                    wb_valid, wb_wr;
  logic [AW-1:0]           wb_dst;
  logic [DW-1:0]           wb_data;
  logic [NSRC-1:0][AW-1:0] rr_addr;
  logic [NSRC-1:0][DW-1:0] rr_raw;
  logic [NSRC-1:0][DW-1:0] rr_data;
  logic [NSRC-1:0][DW-1:0] ex_opnd;
  logic [NSRC-1:0][1:0]    ex_sel;
  logic                    stall, hold_pc, hold_front, exmem_bubble;

  hz_exec_forward #(.AW(AW), .DW(DW), .NSRC(NSRC)) uut (.*);

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  // Scoreboard queues, one entry per driven cycle.
  logic [NSRC-1:0][DW-1:0] q_opnd [$];
  logic [NSRC-1:0][1:0]    q_sel  [$];
  logic [NSRC-1:0]         q_req  [$];
  logic                    q_stall[$];
  logic [NSRC-1:0][DW-1:0] q_rr   [$];
  string                   q_tag  [$];

  // Expected operand from the requirements (R1..R5, R8).
  task automatic predict(input logic [AW-1:0] s, input logic [DW-1:0] rf,
                         output logic [DW-1:0] o, output logic [1:0] sl, output logic rq);
    rq = 1'b0;
    if (s == 3'd7) begin o = pc_val; sl = 2'd3; end
    else if (mem_valid && mem_wr && mem_dst == s) begin o = mem_alu; sl = 2'd1; rq = mem_load; end
    else if (wb_valid && wb_wr && wb_dst == s) begin o = wb_data; sl = 2'd2; end
    else begin o = rf; sl = 2'd0; end
  endtask

  task automatic expect_now(input string tag);
    logic [NSRC-1:0][DW-1:0] o, r;
    logic [NSRC-1:0][1:0]    sl;
    logic [NSRC-1:0]         rq;
    for (int k = 0; k < NSRC; k++) begin
      logic [DW-1:0] ok; logic [1:0] sk; logic qk;
      predict(ex_src_addr[k], ex_rf_val[k], ok, sk, qk);
      o[k] = ok; sl[k] = sk; rq[k] = qk;
      r[k] = (wb_valid && wb_wr && rr_addr[k] == wb_dst) ? wb_data : rr_raw[k];
    end
    q_opnd.push_back(o); q_sel.push_back(sl); q_req.push_back(rq);
    q_stall.push_back(|rq); q_rr.push_back(r); q_tag.push_back(tag);
  endtask

  task automatic idle_stages();
    mem_valid = 0; mem_wr = 0; mem_load = 0; mem_dst = 0; mem_alu = 16'hA000;
    wb_valid = 0; wb_wr = 0; wb_dst = 0; wb_data = 16'hB000;
  endtask

  task automatic base_srcs();
    pc_val = 16'h0100;
    ex_src_addr = {3'd3, 3'd2, 3'd1};
    ex_rf_val   = {16'h1333, 16'h1222, 16'h1111};
    rr_addr     = {3'd6, 3'd5, 3'd4};
    rr_raw      = {16'h2666, 16'h2555, 16'h2444};
  endtask

  // Monitor: results are combinational, compared half a period after driving.
  always @(posedge clk) begin
    if (q_tag.size() != 0) begin
      logic [NSRC-1:0][DW-1:0] eo, er;
      logic [NSRC-1:0][1:0]    es;
      logic [NSRC-1:0]         eq;
      logic                    est;
      string                   t;
      eo = q_opnd.pop_front(); es = q_sel.pop_front(); eq = q_req.pop_front();
      est = q_stall.pop_front(); er = q_rr.pop_front(); t = q_tag.pop_front();
      tests++;
      if (stall !== est || hold_pc !== est || hold_front !== est || exmem_bubble !== est) begin
        fails++;
        $display("FAIL %s (R6/R7): stall/holds %b%b%b%b expected %b", t,
                 stall, hold_pc, hold_front, exmem_bubble, est);
      end
      for (int k = 0; k < NSRC; k++) begin
        if (!eq[k] && (ex_opnd[k] !== eo[k] || ex_sel[k] !== es[k])) begin
          fails++;
          $display("FAIL %s: port %0d opnd %h sel %0d expected %h sel %0d", t, k,
                   ex_opnd[k], ex_sel[k], eo[k], es[k]);
        end
        if (rr_data[k] !== er[k]) begin
          fails++;
          $display("FAIL %s (R9): read port %0d got %h expected %h", t, k, rr_data[k], er[k]);
        end
      end
    end
  end

  // Driver
  initial begin
    logic [15:0] lfsr;
    idle_stages(); base_srcs();
    repeat (2) @(negedge clk);

    // Quiescent: all stages empty, every port from the register file (R5)
    @(negedge clk); idle_stages(); base_srcs(); expect_now("R5 idle");

    // R1: index 7 reads PC even with a matching Mem load
    @(negedge clk); base_srcs(); ex_src_addr[0] = 3'd7;
    mem_valid = 1; mem_wr = 1; mem_load = 1; mem_dst = 3'd7; expect_now("R1 pc source");

    // R2: Mem ALU forwarding
    @(negedge clk); idle_stages(); base_srcs();
    mem_valid = 1; mem_wr = 1; mem_dst = 3'd2; mem_alu = 16'hA2A2; expect_now("R2 mem forward");

    // R3: Mem beats Writeback
    @(negedge clk); idle_stages(); base_srcs();
    mem_valid = 1; mem_wr = 1; mem_dst = 3'd3; mem_alu = 16'hA3A3;
    wb_valid = 1; wb_wr = 1; wb_dst = 3'd3; wb_data = 16'hB3B3; expect_now("R3 mem priority");

    // R4: Writeback to all ports
    @(negedge clk); idle_stages(); base_srcs(); ex_src_addr = {3'd4, 3'd4, 3'd4};
    wb_valid = 1; wb_wr = 1; wb_dst = 3'd4; wb_data = 16'hB4B4; expect_now("R4 wb forward");

    // R8: invalid Mem with match falls through to Writeback
    @(negedge clk); idle_stages(); base_srcs(); ex_src_addr[1] = 3'd5;
    mem_valid = 0; mem_wr = 1; mem_load = 1; mem_dst = 3'd5;
    wb_valid = 1; wb_wr = 1; wb_dst = 3'd5; wb_data = 16'hB5B5; expect_now("R8 mem bubble");

    // R8: Mem not writing, Writeback invalid: register file
    @(negedge clk); idle_stages(); base_srcs();
    mem_valid = 1; mem_wr = 0; mem_load = 1; mem_dst = 3'd1;
    wb_valid = 0; wb_wr = 1; wb_dst = 3'd2; expect_now("R8 no writers");

    // R6/R7: load-use on port 0, then R10 recompute with load in Writeback
    @(negedge clk); idle_stages(); base_srcs();
    mem_valid = 1; mem_wr = 1; mem_load = 1; mem_dst = 3'd1; mem_alu = 16'hDEAD;
    expect_now("R6 load-use stall");
    @(negedge clk); idle_stages();
    wb_valid = 1; wb_wr = 1; wb_dst = 3'd1; wb_data = 16'h10AD; expect_now("R10 recompute");

    // R6: only the last port hits the load
    @(negedge clk); idle_stages(); base_srcs();
    mem_valid = 1; mem_wr = 1; mem_load = 1; mem_dst = 3'd3; expect_now("R6 or of ports");

    // R6: load in Mem with no consumer: no stall
    @(negedge clk); idle_stages(); base_srcs();
    mem_valid = 1; mem_wr = 1; mem_load = 1; mem_dst = 3'd6; expect_now("R6 no consumer");

    // R9: read bypass hit and miss
    @(negedge clk); idle_stages(); base_srcs();
    wb_valid = 1; wb_wr = 1; wb_dst = 3'd5; wb_data = 16'hC5C5; expect_now("R9 bypass hit");
    @(negedge clk); wb_wr = 0; expect_now("R9 bypass disabled");

    // Mixed patterns
    lfsr = 16'hACE1;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      ex_src_addr = {lfsr[2:0], lfsr[5:3], lfsr[8:6]};
      ex_rf_val   = {lfsr, ~lfsr, lfsr ^ 16'h5A5A};
      rr_addr     = {lfsr[11:9], lfsr[14:12], lfsr[3:1]};
      rr_raw      = {~lfsr, lfsr, lfsr + 16'd7};
      pc_val      = lfsr + 16'd3;
      mem_valid = lfsr[9]; mem_wr = lfsr[10]; mem_load = lfsr[11] & lfsr[0];
      mem_dst = lfsr[14:12]; mem_alu = lfsr ^ 16'hF0F0;
      wb_valid = lfsr[13]; wb_wr = lfsr[15]; wb_dst = lfsr[7:5]; wb_data = lfsr ^ 16'h0FF0;
      expect_now("R1-mix R2-mix R4-mix R6-mix");
    end

    @(negedge clk); @(negedge clk);
    done = 1'b1;
  end

  // Finish / watchdog
  initial begin
    int cyc = 0;
    while (!done && cyc < 5000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule